// File: doc/BRIEF.md
# FIFO Status and Interrupt Flag Generator

This block turns the fill counts and push strobes of a transmit FIFO and a receive FIFO into status flags. It does not hold the FIFO storage or the serial shifters. Each FIFO holds 64 entries by default. The block compares each count against fixed limits and against a programmable trigger level for each direction. From these comparisons it produces two views:

- a level view, which follows the counts combinationally;
- a sticky interrupt view, which latches events until software clears them by writing ones.

A mask register selects which latched bits drive the single interrupt line. The overflow events exist only in the interrupt view. When a byte arrives at a full receive FIFO, the block raises a drop strobe so that the FIFO discards that byte.

Bit positions are the same in both views for the seven level conditions:

| Bit | Condition |
|-----|-----------|
| 0 | transmit empty |
| 1 | transmit full |
| 2 | transmit nearly full |
| 3 | transmit trigger |
| 4 | receive empty |
| 5 | receive full |
| 6 | receive trigger |

The interrupt view adds two bits: bit 7 is transmit overflow and bit 8 is receive overflow.

Top module: `fifo_flag_gen`

## Requirements
- R1: `chan_status[0]` is 1 exactly when `tx_count` is 0, and `chan_status[4]` is 1 exactly when `rx_count` is 0, in the same cycle.
- R2: `chan_status[1]` is 1 exactly when `tx_count` equals DEPTH, and `chan_status[5]` is 1 exactly when `rx_count` equals DEPTH.
- R3: `chan_status[2]` (transmit nearly full) is 1 when `tx_count` is at least DEPTH-NEAR_GAP, which is 63 by default. A full FIFO is therefore also nearly full.
- R4: `chan_status[3]` is 1 when `tx_count` >= `tx_trig_lvl`, and `chan_status[6]` is 1 when `rx_count` >= `rx_trig_lvl`. A trigger level of 0 keeps the trigger condition true at all times.
- R5: Bit 7 of `irq_status` latches when `tx_push` is high while `tx_count` equals DEPTH. Bit 8 latches when `rx_push` is high while `rx_count` equals DEPTH. In that receive case, `rx_drop` is 1 in the same cycle. A push at a count below DEPTH sets neither bit. The overflow events have no bit in `chan_status`.
- R6: Each bit of `irq_status[6:0]` sets on the clock edge after its level condition rises from 0 to 1. It then stays set when the condition falls.
- R7: When `clr_we` is high, each bit of `irq_status` written 1 in `clr_data` clears on the next edge. Bits written 0 keep their value. A set event in the same cycle as a clear wins over the clear.
- R8: `mask_wdata` is loaded into `irq_mask` on an edge where `mask_we` is high. `irq_out` is 1 exactly when some bit is set in both `irq_status` and `irq_mask`.
- R9: During reset, `irq_status`, `irq_mask` and `irq_out` are 0. A level condition that is true when reset releases latches on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | Received byte arriving at the receive FIFO |
| tx_trig_lvl | input | TRIG_W | Transmit trigger level |
| rx_trig_lvl | input | TRIG_W | Receive trigger level |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_wdata | input | 9 | New mask value |
| clr_we | input | 1 | Clear strobe for the interrupt view |
| clr_data | input | 9 | Write-1-to-clear bit pattern |
| chan_status | output | 7 | Level status view |
| irq_status | output | 9 | Sticky interrupt view |
| irq_mask | output | 9 | Current mask register |
| irq_out | output | 1 | Combined interrupt line |
| rx_drop | output | 1 | Discard strobe for a byte arriving at a full receive FIFO |

## Verification
The bench builds the block with its defaults: DEPTH of 64, NEAR_GAP of 1 and 6-bit trigger levels. With these values, the full, nearly-full and overflow limits sit at 64 and 63, which the count inputs reach directly. A 6-bit level can only reach 63, so a trigger cannot sit at the full count. The bench therefore exercises the trigger boundary at 63 and at level 0. The table of count and level vectors covers the level view. The directed sequences cover the following:
- rising-edge latching;
- stickiness;
- partial clears;
- set winning over clear;
- pushes one below and exactly at the full count;
- masking of the combined line.

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen #(
  parameter int DEPTH    = 64,
  parameter int TRIG_W   = 6,
  parameter int NEAR_GAP = 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int NSTAT   = 7,
  localparam int NIRQ    = NSTAT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_push,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic [TRIG_W-1:0] tx_trig_lvl,
  input  logic [TRIG_W-1:0] rx_trig_lvl,
  input  logic              mask_we,
  input  logic [NIRQ-1:0]   mask_wdata,
  input  logic              clr_we,
  input  logic [NIRQ-1:0]   clr_data,
  output logic [NSTAT-1:0]  chan_status,
  output logic [NIRQ-1:0]   irq_status,
  output logic [NIRQ-1:0]   irq_mask,
  output logic              irq_out,
  output logic              rx_drop
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] NEAR_CNT = CNT_W'(DEPTH - NEAR_GAP);

  logic [NSTAT-1:0] cond_q;
  logic             tx_ovr_evt;
  logic [NIRQ-1:0]  set_vec;
  logic [NIRQ-1:0]  clr_vec;

  assign chan_status[0] = (tx_count == '0);
  assign chan_status[1] = (tx_count == FULL_CNT);
  assign chan_status[2] = (tx_count >= NEAR_CNT);
  assign chan_status[3] = (tx_count >= CNT_W'(tx_trig_lvl));
  assign chan_status[4] = (rx_count == '0);
  assign chan_status[5] = (rx_count == FULL_CNT);
  assign chan_status[6] = (rx_count >= CNT_W'(rx_trig_lvl));

  assign tx_ovr_evt = tx_push && (tx_count == FULL_CNT);
  assign rx_drop    = rx_push && (rx_count == FULL_CNT);

  assign set_vec = {rx_drop, tx_ovr_evt, chan_status & ~cond_q};
  assign clr_vec = clr_we ? clr_data : '0;
  assign irq_out = |(irq_status & irq_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q     <= '0;
      irq_status <= '0;
      irq_mask   <= '0;
    end else begin
      cond_q     <= chan_status;
      irq_status <= (irq_status & ~clr_vec) | set_vec;
      if (mask_we) irq_mask <= mask_wdata;
    end
  end

  // R5: overflow events latch
  a_r5_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_count == FULL_CNT) |=> irq_status[NSTAT]);
  a_r5_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> irq_status[NSTAT+1]);
  // R3: full lies inside the nearly-full band
  a_r3_full_is_near: assert property (@(posedge clk) disable iff (!rst_n)
    chan_status[1] |-> chan_status[2]);
  // R8: an all-zero mask silences the line
  a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == '0) |=> !irq_out);

  for (genvar k = 0; k < NSTAT; k++) begin : g_chk
    // R6: a rising condition latches
    a_r6_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_status[k]) |=> irq_status[k]);
  end

  for (genvar k = 0; k < NIRQ; k++) begin : g_hold
    // R7: an uncleared bit stays set
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[k] && !(clr_we && clr_data[k])) |=> irq_status[k]);
  end

endmodule

// File: tb/tb_fifo_flag_gen.sv
module tb_fifo_flag_gen;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] tx_count = '0, rx_count = '0;
  logic tx_push = 1'b0, rx_push = 1'b0;
  logic [5:0] tx_trig_lvl = 6'd32, rx_trig_lvl = 6'd32;
  logic mask_we = 1'b0, clr_we = 1'b0;
  logic [8:0] mask_wdata = '0, clr_data = '0;
  logic [6:0] chan_status;
  logic [8:0] irq_status, irq_mask;
  logic irq_out, rx_drop;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fifo_flag_gen dut (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_count), .tx_push(tx_push),
    .rx_count(rx_count), .rx_push(rx_push),
    .tx_trig_lvl(tx_trig_lvl), .rx_trig_lvl(rx_trig_lvl),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_data(clr_data),
    .chan_status(chan_status), .irq_status(irq_status),
    .irq_mask(irq_mask), .irq_out(irq_out), .rx_drop(rx_drop)
  );

  // tx_count, rx_count, tx level, rx level, expected chan_status
  localparam logic [32:0] VEC [6] = '{
    {7'd0,  7'd0,  6'd32, 6'd32, 7'b0010001},
    {7'd63, 7'd10, 6'd63, 6'd10, 7'b1001100},
    {7'd64, 7'd64, 6'd1,  6'd63, 7'b1101110},
    {7'd62, 7'd63, 6'd63, 6'd0,  7'b1000000},
    {7'd1,  7'd0,  6'd0,  6'd1,  7'b0011000},
    {7'd31, 7'd32, 6'd32, 6'd32, 7'b1000000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_data = 9'h1FF;
    step();
    clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk("R9 irq_status in reset", 16'(irq_status), 16'h0);
    chk("R9 irq_mask in reset", 16'(irq_mask), 16'h0);
    chk("R9 irq_out in reset", 16'(irq_out), 16'h0);
    rst_n = 1'b1;
    step();
    chk("R9 empty flags latch after release", 16'(irq_status), 16'h011);
    clear_all();
    chk("R7 clear all", 16'(irq_status), 16'h0);

    // level view table: R1 R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      tx_count = VEC[i][32:26];
      rx_count = VEC[i][25:19];
      tx_trig_lvl = VEC[i][18:13];
      rx_trig_lvl = VEC[i][12:7];
      #1;
      chk($sformatf("R1 R2 R3 R4 vector %0d", i), 16'(chan_status), 16'(VEC[i][6:0]));
      step();
    end

    // idle baseline: no condition true
    tx_count = 7'd5; rx_count = 7'd5; tx_trig_lvl = 6'd32; rx_trig_lvl = 6'd32;
    step();
    clear_all();
    step();
    chk("R6 idle baseline no latch", 16'(irq_status), 16'h0);

    tx_count = 7'd40; rx_count = 7'd40;
    step();
    chk("R6 triggers latch on rise", 16'(irq_status), 16'h048);
    tx_count = 7'd5; rx_count = 7'd5;
    step();
    chk("R6 sticky after fall", 16'(irq_status), 16'h048);
    clr_we = 1'b1; clr_data = 9'h008;
    step();
    clr_we = 1'b0; clr_data = '0;
    chk("R7 partial clear", 16'(irq_status), 16'h040);
    rx_count = 7'd40; clr_we = 1'b1; clr_data = 9'h040;
    step();
    clr_we = 1'b0; clr_data = '0;
    chk("R7 set wins over clear", 16'(irq_status), 16'h040);
    rx_count = 7'd5;
    step();
    clear_all();

    // overflow
    tx_count = 7'd63; tx_push = 1'b1;
    step();
    tx_push = 1'b0;
    chk("R5 push below full no overflow", 16'(irq_status[7]), 16'h0);
    tx_count = 7'd64; tx_push = 1'b1;
    step();
    tx_push = 1'b0;
    chk("R5 tx overflow latch", 16'(irq_status[7]), 16'h1);
    rx_count = 7'd63; rx_push = 1'b1;
    #1;
    chk("R5 no drop below full", 16'(rx_drop), 16'h0);
    step();
    rx_count = 7'd64;
    #1;
    chk("R5 drop at full", 16'(rx_drop), 16'h1);
    step();
    rx_push = 1'b0;
    chk("R5 rx overflow latch", 16'(irq_status[8]), 16'h1);

    // mask
    chk("R8 mask zero line low", 16'(irq_out), 16'h0);
    mask_we = 1'b1; mask_wdata = 9'h100;
    step();
    mask_we = 1'b0;
    chk("R8 mask readback", 16'(irq_mask), 16'h100);
    chk("R8 enabled bit raises line", 16'(irq_out), 16'h1);
    clr_we = 1'b1; clr_data = 9'h100;
    step();
    clr_we = 1'b0; clr_data = '0;
    chk("R8 masked bits keep line low", 16'(irq_out), 16'h0);
    chk("R7 other bits untouched", 16'(irq_status[7]), 16'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule